// File: doc/BRIEF.md
# Touch Controller Register Target on a Two-Wire Bus

This block is the host-facing side of a four-channel touch controller. It is a two-wire serial bus target that runs on the system clock and oversamples SCL and SDA. It finds START, repeated START and STOP conditions and compares the incoming 7-bit address with its own. Of that address, the upper five bits are fixed and the lower two come from a board strap that arrives already decoded. After a matching address it acknowledges each byte it receives, and it can return register data to the master.

A write carries the address with R/W=0, then a register pointer byte, then one or more data bytes, all stored at that pointer. A read first sets the pointer with a write, then sends a repeated START and the address with R/W=1. The target then sends the byte at the pointer, and sends it again each time the master acknowledges, until the master answers with a NACK. The configuration fields are plain outputs. The block raises a one-cycle strobe every time the master acknowledges a byte read from the change-flag register, so that interrupt logic elsewhere can clear its request.

Byte transfer follows the bus's own bit clock. The target never stretches SCL and exerts no back-pressure, so there is no valid/ready edge. All control and status pins are plain levels. The target pulls SDA low only through the `sda_oe` enable.

Top module: `touch_ctl_i2c_target`

## Requirements
- R1: After reset, `sw_shutdown`=0, `sens_sel`=00, `chan_en`=1111, `aclr_sel`=00, `sda_oe`=0 and `chg_read_pulse`=0.
- R2: If the address byte does not match, the target does not acknowledge it. It then ignores every bit until the next START, so later bytes are neither acknowledged nor written. A repeated START that follows with a matching address is served normally.
- R3: The target address is binary 10001 followed by `strap[1:0]`, with the R/W bit as the LSB (0 = write, 1 = read). It matches for every one of the four strap codes: 00 (low), 11 (high), 01 (to SCL) and 10 (to SDA).
- R4: In a write, the address, pointer and data bytes are each sent MSB first and each acknowledged by SDA low in the ninth clock. Data to pointer 00h sets `sw_shutdown`=D7 and `sens_sel`=D6:D5. Data to 01h sets `chan_en`=D3:D0. Data to 04h sets `aclr_sel`=D7:D6. No output changes except through such a write.
- R5: A read (pointer write, repeated START, address with R/W=1) returns the stored byte, MSB first. For 00h, 01h and 04h this is all 8 written bits. For 02h it is {0000, `key_pressed`} and for 03h it is {0000, `key_changed`}. Every byte the master acknowledges is followed by the same register again.
- R6: Writes to 02h, 03h or any unmapped pointer (05h to FFh) are acknowledged and leave all outputs and stored registers unchanged.
- R7: A read from an unmapped pointer returns 00h.
- R8: `chg_read_pulse` is high for exactly one cycle each time the master acknowledges a data byte read from 03h. It stays low when the master NACKs that byte and when other registers are read.
- R9: The target changes its SDA drive only while SCL is low, and it releases SDA after a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock as seen at the pin |
| sda_i | input | 1 | Bus data as seen at the pin |
| sda_oe | output | 1 | 1 = pull SDA low |
| strap | input | 2 | Decoded address strap code |
| key_pressed | input | 4 | Pressed state per channel, shown at 02h |
| key_changed | input | 4 | Change flag per channel, shown at 03h |
| sw_shutdown | output | 1 | Software shutdown request |
| sens_sel | output | 2 | Sensitivity code |
| chan_en | output | 4 | Channel enables |
| aclr_sel | output | 2 | Interrupt auto-clear code |
| chg_read_pulse | output | 1 | One-cycle strobe on an acknowledged 03h read byte |

## Verification
The hardest cases to reach are the ones the master decides in the middle of a transfer. One is ignoring a foreign address and then recovering on a repeated START inside the same transaction. The other is a multi-byte read from 03h that ends in a NACK, which must give exactly one strobe, not two. The bench master drives a wrong strap code in the address, keeps clocking pointer and data bytes through the ignored phase, and then issues a repeated START with the right address. It also reads 03h for two bytes, acknowledging the first and refusing the second, and counts the strobes.

// File: rtl/touch_i2c_pkg.sv
package touch_i2c_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_PTR, S_WDATA, S_ACK, S_RDATA, S_MACK
  } eng_state_t;

  localparam logic [7:0] REG_CFG  = 8'h00;
  localparam logic [7:0] REG_CHAN = 8'h01;
  localparam logic [7:0] REG_PRS  = 8'h02;
  localparam logic [7:0] REG_CHG  = 8'h03;
  localparam logic [7:0] REG_ACLR = 8'h04;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC-2:0], sda_i};
      scl_d  <= scl_ff[SYNC-1];
      sda_d  <= sda_ff[SYNC-1];
    end
  end

  assign scl_s     = scl_ff[SYNC-1];
  assign sda_s     = sda_ff[SYNC-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import touch_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b10001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] strap,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       chg_pulse
);
  eng_state_t state, nxt_st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       macked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      nxt_st    <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      macked    <= 1'b0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      chg_pulse <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      chg_pulse <= 1'b0;
      if (start_det) begin
        state <= S_ADDR;
        cnt   <= '0;
      end else if (stop_det) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_ADDR, S_PTR, S_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == S_ADDR) begin
                if (sh[7:1] == {ADDR_HI, strap}) begin
                  state  <= S_ACK;
                  nxt_st <= sh[0] ? S_RDATA : S_PTR;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_PTR) begin
                ptr    <= sh;
                state  <= S_ACK;
                nxt_st <= S_WDATA;
              end else begin
                wr_en   <= 1'b1;
                wr_data <= sh;
                state   <= S_ACK;
                nxt_st  <= S_WDATA;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              state <= nxt_st;
              cnt   <= '0;
              if (nxt_st == S_RDATA) tx <= rd_data;
            end
          end
          S_RDATA: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                state <= S_MACK;
              end else begin
                tx  <= {tx[6:0], 1'b0};
                cnt <= cnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              macked <= ~sda_s;
              if (!sda_s && ptr == REG_CHG) chg_pulse <= 1'b1;
            end else if (scl_fall) begin
              if (macked) begin
                state <= S_RDATA;
                cnt   <= '0;
                tx    <= rd_data;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = (state == S_ACK) | ((state == S_RDATA) & ~tx[7]);
endmodule

// File: rtl/touch_regbank.sv
module touch_regbank
  import touch_i2c_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     addr,
  input  logic [7:0]     wr_data,
  input  logic [NCH-1:0] key_pressed,
  input  logic [NCH-1:0] key_changed,
  output logic [7:0]     rd_data,
  output logic           sw_shutdown,
  output logic [1:0]     sens_sel,
  output logic [NCH-1:0] chan_en,
  output logic [1:0]     aclr_sel
);
  localparam int PADW = 8 - NCH;
  logic [7:0] cfg_q, chan_q, aclr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 8'h00;
      chan_q <= 8'hFF;
      aclr_q <= 8'h00;
    end else if (wr_en) begin
      case (addr)
        REG_CFG:  cfg_q  <= wr_data;
        REG_CHAN: chan_q <= wr_data;
        REG_ACLR: aclr_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      REG_CFG:  rd_data = cfg_q;
      REG_CHAN: rd_data = chan_q;
      REG_PRS:  rd_data = {{PADW{1'b0}}, key_pressed};
      REG_CHG:  rd_data = {{PADW{1'b0}}, key_changed};
      REG_ACLR: rd_data = aclr_q;
      default:  rd_data = 8'h00;
    endcase
  end

  assign sw_shutdown = cfg_q[7];
  assign sens_sel    = cfg_q[6:5];
  assign chan_en     = chan_q[NCH-1:0];
  assign aclr_sel    = aclr_q[7:6];
endmodule

// File: rtl/touch_ctl_i2c_target.sv
module touch_ctl_i2c_target #(
  parameter int         NCH     = 4,
  parameter int         SYNC    = 2,
  parameter logic [4:0] ADDR_HI = 5'b10001
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  input  logic [1:0]     strap,
  input  logic [NCH-1:0] key_pressed,
  input  logic [NCH-1:0] key_changed,
  output logic           sw_shutdown,
  output logic [1:0]     sens_sel,
  output logic [NCH-1:0] chan_en,
  output logic [1:0]     aclr_sel,
  output logic           chg_read_pulse
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, wr_data, rd_data;
  logic       wr_en;

  i2c_bus_cond #(.SYNC(SYNC)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap), .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .chg_pulse(chg_read_pulse)
  );

  touch_regbank #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wr_data(wr_data),
    .key_pressed(key_pressed), .key_changed(key_changed), .rd_data(rd_data),
    .sw_shutdown(sw_shutdown), .sens_sel(sens_sel), .chan_en(chan_en),
    .aclr_sel(aclr_sel)
  );
endmodule

// File: rtl/touch_ctl_i2c_target_chk.sv
module touch_ctl_i2c_target_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           scl_s,
  input logic           start_det,
  input logic           sda_oe,
  input logic           wr_en,
  input logic [7:0]     ptr,
  input logic           sw_shutdown,
  input logic [1:0]     sens_sel,
  input logic [NCH-1:0] chan_en,
  input logic [1:0]     aclr_sel,
  input logic           chg_read_pulse
);
  logic [NCH+4:0] fields;
  assign fields = {sw_shutdown, sens_sel, chan_en, aclr_sel};

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_read_pulse |=> !chg_read_pulse);

  p_pulse_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_read_pulse |-> ptr == 8'h03);

  p_release_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  p_fields_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fields) |-> $past(wr_en));

  p_ro_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (ptr == 8'h02 || ptr == 8'h03 || ptr > 8'h04)) |=> $stable(fields));
endmodule

bind touch_ctl_i2c_target touch_ctl_i2c_target_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .sda_oe(sda_oe), .wr_en(wr_en), .ptr(ptr), .sw_shutdown(sw_shutdown),
  .sens_sel(sens_sel), .chan_en(chan_en), .aclr_sel(aclr_sel),
  .chg_read_pulse(chg_read_pulse)
);

// File: tb/touch_ctl_i2c_target_tb.sv
`timescale 1ns/1ps
module touch_ctl_i2c_target_tb;
  localparam int QT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap_v = 2'b00;
  logic [3:0] pressed_v = 4'h0, changed_v = 4'h0;
  logic sda_oe, sw_shutdown, chg_read_pulse;
  logic [1:0] sens_sel, aclr_sel;
  logic [3:0] chan_en;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, n_pulse = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  logic [7:0] m_cfg = 8'h00, m_chan = 8'hFF, m_aclr = 8'h00;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  touch_ctl_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap_v), .key_pressed(pressed_v), .key_changed(changed_v),
    .sw_shutdown(sw_shutdown), .sens_sel(sens_sel), .chan_en(chan_en),
    .aclr_sel(aclr_sel), .chg_read_pulse(chg_read_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock reference compare of the field outputs (R4, R6)
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk({sw_shutdown, sens_sel, chan_en, aclr_sel} ==
          {m_cfg[7], m_cfg[6:5], m_chan[3:0], m_aclr[7:6]}, "R4/R6 field model",
          {sw_shutdown, sens_sel, chan_en, aclr_sel},
          {m_cfg[7], m_cfg[6:5], m_chan[3:0], m_aclr[7:6]});
    end
    if (rst_n && sda_oe != prev_oe)
      chk(scl_m == 1'b0, "R9 drive change with SCL low", scl_m, 0);
    prev_oe = sda_oe;
  end

  always @(posedge clk) if (rst_n && chg_read_pulse) n_pulse++;

  task automatic qw(); repeat (QT) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); acked = !sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic rx_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(); scl_m = 1'b1; qw(); d = {d[6:0], sda_line}; qw(); scl_m = 1'b0; qw();
    end
    sda_m = mack ? 1'b0 : 1'b1; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] s, input bit rd);
    return {5'b10001, s, rd};
  endfunction

  task automatic do_write(input logic [7:0] p, input logic [7:0] d, input string tag);
    bit a0, a1, a2;
    bus_start();
    tx_byte(addr_byte(strap_v, 1'b0), a0);
    tx_byte(p, a1);
    cmp_en = 1'b0;
    tx_byte(d, a2);
    case (p)
      8'h00: m_cfg = d;
      8'h01: m_chan = d;
      8'h04: m_aclr = d;
      default: ;
    endcase
    cmp_en = 1'b1;
    bus_stop();
    chk(a0 && a1 && a2, tag, {a0, a1, a2}, 3'b111);
  endtask

  task automatic do_read(input logic [7:0] p, input int n, output logic [7:0] b0,
                         output logic [7:0] b1, output bit acks);
    bit a0, a1, a2;
    bus_start();
    tx_byte(addr_byte(strap_v, 1'b0), a0);
    tx_byte(p, a1);
    bus_start();
    tx_byte(addr_byte(strap_v, 1'b1), a2);
    rx_byte(n > 1, b0);
    b1 = 8'h00;
    if (n > 1) rx_byte(1'b0, b1);
    bus_stop();
    acks = a0 && a1 && a2;
  endtask

  task automatic read_chk(input logic [7:0] p, input logic [7:0] exp, input string tag);
    logic [7:0] b0, b1;
    bit ak;
    do_read(p, 1, b0, b1, ak);
    chk(ak && b0 == exp, tag, b0, exp);
  endtask

  initial begin
    logic [7:0] b0, b1;
    bit ak, a0, a1, a2;
    int p0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sw_shutdown == 0 && sens_sel == 0 && aclr_sel == 0, "R1 cfg reset",
        {sw_shutdown, sens_sel, aclr_sel}, 0);
    chk(chan_en == 4'hF, "R1 chan_en reset", chan_en, 4'hF);
    chk(sda_oe == 0 && chg_read_pulse == 0, "R1 bus idle", {sda_oe, chg_read_pulse}, 0);
    cmp_en = 1'b1;

    // R4 writes
    do_write(8'h00, 8'hC0, "R4 ack write cfg");
    chk(sw_shutdown == 1 && sens_sel == 2'b10, "R4 cfg fields", {sw_shutdown, sens_sel}, 3'b110);
    do_write(8'h01, 8'h5A, "R4 ack write chan");
    chk(chan_en == 4'hA, "R4 chan field", chan_en, 4'hA);
    do_write(8'h04, 8'h80, "R4 ack write aclr");
    chk(aclr_sel == 2'b10, "R4 aclr field", aclr_sel, 2);

    // R5 reads
    read_chk(8'h00, 8'hC0, "R5 read cfg");
    read_chk(8'h01, 8'h5A, "R5 read chan");
    read_chk(8'h04, 8'h80, "R5 read aclr");
    pressed_v = 4'h9;
    read_chk(8'h02, 8'h09, "R5 read pressed");
    changed_v = 4'h6;
    read_chk(8'h03, 8'h06, "R5 read changed");

    // R7 unmapped reads
    read_chk(8'h07, 8'h00, "R7 read 07h");
    read_chk(8'h80, 8'h00, "R7 read 80h");

    // R6 discarded writes
    do_write(8'h02, 8'hFF, "R6 ack write 02h");
    do_write(8'h03, 8'hFF, "R6 ack write 03h");
    do_write(8'h07, 8'hFF, "R6 ack write 07h");
    read_chk(8'h00, 8'hC0, "R6 cfg kept");
    read_chk(8'h01, 8'h5A, "R6 chan kept");
    read_chk(8'h04, 8'h80, "R6 aclr kept");

    // R3 every strap code
    for (int s = 0; s < 4; s++) begin
      strap_v = s[1:0];
      do_write(8'h04, {s[1:0], 6'b0}, "R3 strap ack");
      chk(aclr_sel == s[1:0], "R3 strap write", aclr_sel, s);
    end

    // R2 mismatch ignored until next START
    bus_start();
    tx_byte(addr_byte(2'b01, 1'b0), a0);
    tx_byte(8'h00, a1);
    tx_byte(8'h00, a2);
    bus_stop();
    chk(!a0 && !a1 && !a2, "R2 no ack after mismatch", {a0, a1, a2}, 0);
    chk(sw_shutdown == 1'b1, "R2 cfg untouched", sw_shutdown, 1);
    bus_start();
    tx_byte(addr_byte(2'b00, 1'b0), a0);
    tx_byte(8'h01, a1);
    bus_start();
    tx_byte(addr_byte(strap_v, 1'b0), a2);
    chk(!a0 && !a1 && a2, "R2 recover on repeated START", {a0, a1, a2}, 3'b001);
    tx_byte(8'h01, a1);
    cmp_en = 1'b0;
    tx_byte(8'h33, a2);
    m_chan = 8'h33;
    cmp_en = 1'b1;
    bus_stop();
    chk(a1 && a2 && chan_en == 4'h3, "R2 write after recovery", chan_en, 3);

    // R8 change-flag read strobe
    p0 = n_pulse;
    do_read(8'h03, 2, b0, b1, ak);
    chk(ak && b0 == 8'h06 && b1 == 8'h06, "R5 repeated byte 03h", {b0, b1}, 16'h0606);
    chk(n_pulse == p0 + 1, "R8 one strobe for ack then nack", n_pulse - p0, 1);
    p0 = n_pulse;
    do_read(8'h02, 2, b0, b1, ak);
    chk(n_pulse == p0, "R8 no strobe for 02h", n_pulse - p0, 0);
    p0 = n_pulse;
    do_read(8'h03, 1, b0, b1, ak);
    chk(n_pulse == p0, "R8 no strobe on nack", n_pulse - p0, 0);

    cmp_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule